// File: doc/BRIEF.md
# Four-Point Add-Only Complex Transform with Coherent Bin Sum

This block turns a stream of complex samples into a four-point discrete Fourier transform. Samples arrive with an input strobe. The block collects them in groups of four that do not overlap, and for each complete group it produces the four frequency bins. Every twiddle factor at this size is 1, -1, +j or -j, so the transform is built only from adders, subtractors and swaps of the real and imaginary parts. There are no multipliers anywhere in the datapath.

Alongside the bins, the block adds the four bins coherently, real parts with real parts and imaginary parts with imaginary parts. The result is one integrated complex value per group, which feeds a later integrate stage of a receive chain.

Internal words grow by one bit per radix-2 stage and by two more bits in the bin adder, so no bit is ever discarded. All outputs are registered. They change only when a new group result appears and hold their values between results.

Top module: `quad_dft4`

## Requirements
- R1: While rst_n is low, and after its release until the first group completes, out_valid is 0 and every bin and sum output reads 0.
- R2: Accepted samples (in_valid high at a rising clock edge) are grouped four at a time with no overlap, and cycles with in_valid low are skipped. Exactly one out_valid pulse of one cycle is produced per completed group.
- R3: If the fourth sample of a group is accepted at clock edge n, out_valid is high when sampled at edge n+2. This is a fixed two-cycle latency.
- R4: Bin 0 (bits [BIN_W-1:0] of bins_i/bins_q) equals x0+x1+x2+x3, where x0 is the first sample of the group.
- R5: Bin 2 (bits [3*BIN_W-1:2*BIN_W]) equals (x0+x2)-(x1+x3).
- R6: Bin 1 (bits [2*BIN_W-1:BIN_W]) equals (x0-x2) - j(x1-x3). Its real part is (x0-x2).I + (x1-x3).Q and its imaginary part is (x0-x2).Q - (x1-x3).I.
- R7: Bin 3 (bits [4*BIN_W-1:3*BIN_W]) equals (x0-x2) + j(x1-x3). Its real part is (x0-x2).I - (x1-x3).Q and its imaginary part is (x0-x2).Q + (x1-x3).I.
- R8: sum_i and sum_q are the coherent sums of the four bins, taken separately over I and over Q. They equal exactly 4 times x0.
- R9: For any full-scale input, including -2048 on every part, bins (BIN_W = IN_W+2 bits, signed) and sums (SUM_W = IN_W+4 bits, signed) are exact, with no wrap.
- R10: Between out_valid pulses, all bin and sum outputs hold their last values.
- R11: For a group holding one full cycle of a complex tone (A, jA, -A, -jA), bin 0 reads 0 and bin 1 reads 4A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_i | input | IN_W | Sample real part, two's complement |
| in_q | input | IN_W | Sample imaginary part, two's complement |
| out_valid | output | 1 | One-cycle pulse per group result |
| bins_i | output | 4*BIN_W | Real parts of bins 0..3, bin k at [k*BIN_W +: BIN_W] |
| bins_q | output | 4*BIN_W | Imaginary parts of bins 0..3, same packing |
| sum_i | output | SUM_W | Coherent sum of the bin real parts |
| sum_q | output | SUM_W | Coherent sum of the bin imaginary parts |

## Verification
The bench builds the block with its default IN_W of 12, so bins are 14 bits and sums are 16 bits. At this width, full-scale negative inputs drive bin 0 to -8192, which is exactly the most negative 14-bit value. Mixed extremes push bin 1 to +/-8190, so the edges of the growth budget are reached directly. The narrow default also keeps random groups cheap, so many distinct groups, back-to-back groups and groups with gaps between samples all fit in a short run against a behavioural transform computed with explicit twiddle factors.

// File: rtl/dft4_pkg.sv
package dft4_pkg;
   localparam int N_PTS = 4;
   localparam int CNT_W = $clog2(N_PTS);
   // How the second operand is rotated before it is added to the first
   typedef enum logic [1:0] {
      ROT_ID,   // a + b
      ROT_NEG,  // a - b
      ROT_MJ,   // a + (-j)*b
      ROT_PJ    // a + (+j)*b
   } rot_e;
endpackage

// File: rtl/dft4_gather.sv
module dft4_gather
   import dft4_pkg::*;
#(
   parameter int IN_W = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [IN_W-1:0]         in_i,
   input  logic [IN_W-1:0]         in_q,
   output logic                    grp_valid,
   output logic [N_PTS*IN_W-1:0]   grp_i,
   output logic [N_PTS*IN_W-1:0]   grp_q
);
   localparam int HELD = N_PTS - 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HELD);

   logic [CNT_W-1:0] fill;
   logic [IN_W-1:0]  hold_i [HELD];
   logic [IN_W-1:0]  hold_q [HELD];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill <= '0;
      end else if (in_valid) begin
         fill <= (fill == LAST) ? '0 : fill + 1'b1;
      end
   end

   for (genvar k = 0; k < HELD; k++) begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_i[k] <= '0;
            hold_q[k] <= '0;
         end else if (in_valid && fill == CNT_W'(k)) begin
            hold_i[k] <= in_i;
            hold_q[k] <= in_q;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_valid <= 1'b0;
         grp_i     <= '0;
         grp_q     <= '0;
      end else begin
         grp_valid <= in_valid && (fill == LAST);
         if (in_valid && fill == LAST) begin
            for (int k = 0; k < HELD; k++) begin
               grp_i[k*IN_W +: IN_W] <= hold_i[k];
               grp_q[k*IN_W +: IN_W] <= hold_q[k];
            end
            grp_i[HELD*IN_W +: IN_W] <= in_i;
            grp_q[HELD*IN_W +: IN_W] <= in_q;
         end
      end
   end
endmodule

// File: rtl/dft4_rot_add.sv
module dft4_rot_add
   import dft4_pkg::*;
#(
   parameter int   W   = 12,
   parameter rot_e ROT = ROT_ID
) (
   input  logic signed [W-1:0] a_i,
   input  logic signed [W-1:0] a_q,
   input  logic signed [W-1:0] b_i,
   input  logic signed [W-1:0] b_q,
   output logic signed [W:0]   y_i,
   output logic signed [W:0]   y_q
);
   if (W < 2) begin : g_bad_w
      $error("dft4_rot_add: W must be at least 2");
   end

   logic signed [W:0] ai, aq, bi, bq;
   assign ai = {a_i[W-1], a_i};
   assign aq = {a_q[W-1], a_q};
   assign bi = {b_i[W-1], b_i};
   assign bq = {b_q[W-1], b_q};

   if (ROT == ROT_ID) begin : g_id
      assign y_i = ai + bi;
      assign y_q = aq + bq;
   end else if (ROT == ROT_NEG) begin : g_neg
      assign y_i = ai - bi;
      assign y_q = aq - bq;
   end else if (ROT == ROT_MJ) begin : g_mj
      // -j*(bi + j bq) = bq - j bi
      assign y_i = ai + bq;
      assign y_q = aq - bi;
   end else begin : g_pj
      // +j*(bi + j bq) = -bq + j bi
      assign y_i = ai - bq;
      assign y_q = aq + bi;
   end
endmodule

// File: rtl/dft4_core.sv
module dft4_core
   import dft4_pkg::*;
#(
   parameter int IN_W = 12,
   localparam int MID_W = IN_W + 1,
   localparam int BIN_W = IN_W + CNT_W
) (
   input  logic [N_PTS*IN_W-1:0]   grp_i,
   input  logic [N_PTS*IN_W-1:0]   grp_q,
   output logic [N_PTS*BIN_W-1:0]  bins_i,
   output logic [N_PTS*BIN_W-1:0]  bins_q
);
   localparam int HALF = N_PTS / 2;

   // first radix-2 stage: pair sample p with sample p+2
   logic signed [MID_W-1:0] ev_i [HALF];
   logic signed [MID_W-1:0] ev_q [HALF];
   logic signed [MID_W-1:0] od_i [HALF];
   logic signed [MID_W-1:0] od_q [HALF];

   for (genvar p = 0; p < HALF; p++) begin : g_st1
      dft4_rot_add #(.W(IN_W), .ROT(ROT_ID)) u_sum (
         .a_i(grp_i[p*IN_W +: IN_W]),        .a_q(grp_q[p*IN_W +: IN_W]),
         .b_i(grp_i[(p+HALF)*IN_W +: IN_W]), .b_q(grp_q[(p+HALF)*IN_W +: IN_W]),
         .y_i(ev_i[p]), .y_q(ev_q[p])
      );
      dft4_rot_add #(.W(IN_W), .ROT(ROT_NEG)) u_dif (
         .a_i(grp_i[p*IN_W +: IN_W]),        .a_q(grp_q[p*IN_W +: IN_W]),
         .b_i(grp_i[(p+HALF)*IN_W +: IN_W]), .b_q(grp_q[(p+HALF)*IN_W +: IN_W]),
         .y_i(od_i[p]), .y_q(od_q[p])
      );
   end

   // second stage: even bins from the sums, odd bins from the rotated differences
   for (genvar k = 0; k < N_PTS; k++) begin : g_st2
      localparam rot_e R = (k == 0) ? ROT_ID :
                           (k == 1) ? ROT_MJ :
                           (k == 2) ? ROT_NEG : ROT_PJ;
      logic signed [BIN_W-1:0] y_i, y_q;
      if (k % 2 == 0) begin : g_even
         dft4_rot_add #(.W(MID_W), .ROT(R)) u_b (
            .a_i(ev_i[0]), .a_q(ev_q[0]), .b_i(ev_i[1]), .b_q(ev_q[1]),
            .y_i(y_i), .y_q(y_q)
         );
      end else begin : g_odd
         dft4_rot_add #(.W(MID_W), .ROT(R)) u_b (
            .a_i(od_i[0]), .a_q(od_q[0]), .b_i(od_i[1]), .b_q(od_q[1]),
            .y_i(y_i), .y_q(y_q)
         );
      end
      assign bins_i[k*BIN_W +: BIN_W] = y_i;
      assign bins_q[k*BIN_W +: BIN_W] = y_q;
   end
endmodule

// File: rtl/dft4_accum.sv
module dft4_accum
   import dft4_pkg::*;
#(
   parameter int BIN_W = 14,
   localparam int SUM_W = BIN_W + CNT_W
) (
   input  logic [N_PTS*BIN_W-1:0] bins_i,
   input  logic [N_PTS*BIN_W-1:0] bins_q,
   output logic [SUM_W-1:0]       sum_i,
   output logic [SUM_W-1:0]       sum_q
);
   localparam int EXT = SUM_W - BIN_W;

   always_comb begin
      sum_i = '0;
      sum_q = '0;
      for (int k = 0; k < N_PTS; k++) begin
         sum_i = sum_i + {{EXT{bins_i[k*BIN_W + BIN_W-1]}}, bins_i[k*BIN_W +: BIN_W]};
         sum_q = sum_q + {{EXT{bins_q[k*BIN_W + BIN_W-1]}}, bins_q[k*BIN_W +: BIN_W]};
      end
   end
endmodule

// File: rtl/quad_dft4.sv
module quad_dft4
   import dft4_pkg::*;
#(
   parameter int IN_W = 12,
   localparam int BIN_W = IN_W + CNT_W,
   localparam int SUM_W = BIN_W + CNT_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [IN_W-1:0]         in_i,
   input  logic [IN_W-1:0]         in_q,
   output logic                    out_valid,
   output logic [N_PTS*BIN_W-1:0]  bins_i,
   output logic [N_PTS*BIN_W-1:0]  bins_q,
   output logic [SUM_W-1:0]        sum_i,
   output logic [SUM_W-1:0]        sum_q
);
   if (IN_W < 2) begin : g_bad_in_w
      $error("quad_dft4: IN_W must be at least 2");
   end

   logic                    grp_valid;
   logic [N_PTS*IN_W-1:0]   grp_i, grp_q;
   logic [N_PTS*BIN_W-1:0]  cb_i, cb_q;
   logic [SUM_W-1:0]        cs_i, cs_q;

   dft4_gather #(.IN_W(IN_W)) u_gather (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
      .grp_valid(grp_valid), .grp_i(grp_i), .grp_q(grp_q)
   );

   dft4_core #(.IN_W(IN_W)) u_core (
      .grp_i(grp_i), .grp_q(grp_q), .bins_i(cb_i), .bins_q(cb_q)
   );

   dft4_accum #(.BIN_W(BIN_W)) u_accum (
      .bins_i(cb_i), .bins_q(cb_q), .sum_i(cs_i), .sum_q(cs_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         bins_i    <= '0;
         bins_q    <= '0;
         sum_i     <= '0;
         sum_q     <= '0;
      end else begin
         out_valid <= grp_valid;
         if (grp_valid) begin
            bins_i <= cb_i;
            bins_q <= cb_q;
            sum_i  <= cs_i;
            sum_q  <= cs_q;
         end
      end
   end
endmodule

// File: rtl/quad_dft4_chk.sv
module quad_dft4_chk
   import dft4_pkg::*;
#(
   parameter int IN_W = 12,
   localparam int BIN_W = IN_W + CNT_W,
   localparam int SUM_W = BIN_W + CNT_W
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic [IN_W-1:0]         in_i,
   input logic [IN_W-1:0]         in_q,
   input logic                    out_valid,
   input logic [N_PTS*BIN_W-1:0]  bins_i,
   input logic [N_PTS*BIN_W-1:0]  bins_q,
   input logic [SUM_W-1:0]        sum_i,
   input logic [SUM_W-1:0]        sum_q
);
   localparam int XW = SUM_W - IN_W;

   // checker-side count of accepted samples and the first sample of each group
   logic [CNT_W-1:0] seen;
   logic [IN_W-1:0]  first_i, first_q, grp0_i, grp0_q;
   logic             fourth;

   assign fourth = in_valid && (seen == CNT_W'(N_PTS-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen    <= '0;
         first_i <= '0;
         first_q <= '0;
         grp0_i  <= '0;
         grp0_q  <= '0;
      end else if (in_valid) begin
         seen <= seen + 1'b1;
         if (seen == '0) begin
            first_i <= in_i;
            first_q <= in_q;
         end
         if (fourth) begin
            grp0_i <= first_i;
            grp0_q <= first_q;
         end
      end
   end

   logic [SUM_W-1:0] four_x0_i, four_x0_q;
   assign four_x0_i = {{XW{grp0_i[IN_W-1]}}, grp0_i} << CNT_W;
   assign four_x0_q = {{XW{grp0_q[IN_W-1]}}, grp0_q} << CNT_W;

   // R3: fixed two-cycle latency from fourth accepted sample
   a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
      fourth |-> ##2 out_valid);

   // R2: a result only follows a completed group
   a_r2_only_after_group: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(fourth, 2));

   // R2: one-cycle pulse
   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R8: coherent sum equals four times the first sample
   a_r8_sum_is_4x0: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (sum_i == four_x0_i && sum_q == four_x0_q));

   // R10: outputs hold between results
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(bins_i) && $stable(bins_q) && $stable(sum_i) && $stable(sum_q)));
endmodule

bind quad_dft4 quad_dft4_chk #(.IN_W(IN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
   .out_valid(out_valid), .bins_i(bins_i), .bins_q(bins_q),
   .sum_i(sum_i), .sum_q(sum_q)
);

// File: tb/tb_quad_dft4.sv
`timescale 1ns/1ps
module tb_quad_dft4;
   localparam int IN_W = 12;
   localparam int BW   = IN_W + 2;
   localparam int SW   = IN_W + 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [IN_W-1:0] in_i = '0, in_q = '0;
   logic            out_valid;
   logic [4*BW-1:0] bins_i, bins_q;
   logic [SW-1:0]   sum_i, sum_q;

   always #4 clk = ~clk;   // 125 MHz

   quad_dft4 #(.IN_W(IN_W)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
      .out_valid(out_valid), .bins_i(bins_i), .bins_q(bins_q),
      .sum_i(sum_i), .sum_q(sum_q)
   );

   int checks = 0, errors = 0;
   bit done = 0;

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int bi(int k); return int'($signed(bins_i[k*BW +: BW])); endfunction
   function automatic int bq(int k); return int'($signed(bins_q[k*BW +: BW])); endfunction

   // ---------------- behavioural reference ----------------
   int qi[$], qq[$];
   int s1_v = 0, s1_bi[4], s1_bq[4], s1_si, s1_sq, s1_x0i, s1_x0q;
   int e_v = 0, e_bi[4], e_bq[4], e_si, e_sq, e_x0i, e_x0q;
   int groups = 0, pulses = 0;
   bit armed = 0;

   function automatic void ref_dft();
      int cs[4] = '{1, 0, -1, 0};
      int sn[4] = '{0, -1, 0, 1};
      s1_si = 0; s1_sq = 0;
      for (int k = 0; k < 4; k++) begin
         s1_bi[k] = 0; s1_bq[k] = 0;
         for (int n = 0; n < 4; n++) begin
            int m = (k * n) % 4;
            s1_bi[k] += qi[n] * cs[m] - qq[n] * sn[m];
            s1_bq[k] += qi[n] * sn[m] + qq[n] * cs[m];
         end
         s1_si += s1_bi[k];
         s1_sq += s1_bq[k];
      end
      s1_x0i = qi[0]; s1_x0q = qq[0];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         qi.delete(); qq.delete(); s1_v = 0; e_v = 0;
         for (int k = 0; k < 4; k++) begin e_bi[k] = 0; e_bq[k] = 0; end
         e_si = 0; e_sq = 0;
      end else begin
         e_v = s1_v;
         if (s1_v) begin
            e_bi = s1_bi; e_bq = s1_bq; e_si = s1_si; e_sq = s1_sq;
            e_x0i = s1_x0i; e_x0q = s1_x0q;
         end
         s1_v = 0;
         if (in_valid) begin
            qi.push_back(int'($signed(in_i)));
            qq.push_back(int'($signed(in_q)));
            if (qi.size() == 4) begin
               ref_dft(); s1_v = 1; groups++;
               qi.delete(); qq.delete();
            end
         end
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (armed) begin
         check("R3 out_valid", int'(out_valid), e_v);
         if (out_valid) pulses++;
         check(e_v ? "R4 bin0 I" : "R10 hold bin0 I", bi(0), e_bi[0]);
         check(e_v ? "R4 bin0 Q" : "R10 hold bin0 Q", bq(0), e_bq[0]);
         check("R6 bin1 I", bi(1), e_bi[1]);
         check("R6 bin1 Q", bq(1), e_bq[1]);
         check("R5 bin2 I", bi(2), e_bi[2]);
         check("R5 bin2 Q", bq(2), e_bq[2]);
         check("R7 bin3 I", bi(3), e_bi[3]);
         check("R7 bin3 Q", bq(3), e_bq[3]);
         check("R8 sum I", int'($signed(sum_i)), e_si);
         check("R8 sum Q", int'($signed(sum_q)), e_sq);
         if (out_valid) begin
            check("R8 sum I is 4*x0", int'($signed(sum_i)), 4 * e_x0i);
            check("R8 sum Q is 4*x0", int'($signed(sum_q)), 4 * e_x0q);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic send(int i, int q);
      @(negedge clk);
      in_valid = 1'b1; in_i = IN_W'(i); in_q = IN_W'(q);
   endtask

   task automatic idle(int n);
      @(negedge clk);
      in_valid = 1'b0;
      for (int c = 1; c < n; c++) @(negedge clk);
   endtask

   task automatic group4(int i0, int q0, int i1, int q1, int i2, int q2, int i3, int q3);
      send(i0, q0); send(i1, q1); send(i2, q2); send(i3, q3);
      idle(3);
   endtask

   // watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 out_valid in reset", int'(out_valid), 0);
      check("R1 sum_i in reset", int'($signed(sum_i)), 0);
      check("R1 bin0 in reset", bi(0), 0);
      @(negedge clk); rst_n = 1'b1;
      armed = 1;
      idle(2);
      check("R1 out_valid after release", int'(out_valid), 0);

      // DC group
      group4(100, -50, 100, -50, 100, -50, 100, -50);
      check("R4 DC bin0 I", bi(0), 400);
      check("R5 DC bin2 I", bi(2), 0);

      // R11: one full cycle of a complex tone
      group4(300, 0, 0, 300, -300, 0, 0, -300);
      check("R11 tone bin0 I", bi(0), 0);
      check("R11 tone bin0 Q", bq(0), 0);
      check("R11 tone bin1 I", bi(1), 1200);

      // alternating sign lands in bin 2
      group4(500, 7, -500, 7, 500, 7, -500, 7);
      check("R5 alt bin2 I", bi(2), 2000);

      // R9: full-scale extremes
      group4(-2048, -2048, -2048, -2048, -2048, -2048, -2048, -2048);
      check("R9 min bin0 I", bi(0), -8192);
      check("R9 min sum Q", int'($signed(sum_q)), -8192);
      group4(2047, -2048, 2047, 2047, -2048, 2047, -2048, -2048);
      check("R9 mix bin1 I", bi(1), 8190);
      check("R9 mix bin1 Q", bq(1), -8190);

      // R2: gaps between accepted samples
      send(11, 22); idle(2); send(-33, 44); idle(1); send(55, -66); idle(4); send(-77, 88);
      idle(4);

      // R2: back-to-back groups, random content
      for (int g = 0; g < 40; g++) begin
         for (int s = 0; s < 4; s++)
            send(int'($urandom % 4096) - 2048, int'($urandom % 4096) - 2048);
      end
      idle(5);

      // random gaps
      for (int s = 0; s < 60; s++) begin
         send(int'($urandom % 4096) - 2048, int'($urandom % 4096) - 2048);
         if ($urandom % 3 == 0) idle(int'($urandom % 3) + 1);
      end
      idle(6);

      check("R2 pulses per group", pulses, groups);
      check("R2 group count", groups, 1 + 1 + 1 + 2 + 1 + 40 + 15);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule